// File: doc/BRIEF.md
# Timer Channel Compare Output Generator

This block is one compare channel of a general-purpose timer. It has its own counter. The counter runs either edge-aligned, counting up from zero to a reload limit and wrapping, or centre-aligned, counting up to the limit and back down to zero. Each clock the channel compares the counter with a compare register. From that result it drives a registered output-prepare level, which a later output stage would turn into a pin.

A three-bit mode field picks what the prepare level does:

- hold its level;
- set on a match;
- clear on a match;
- toggle on a match;
- be forced low;
- be forced high;
- follow one of two pulse-width patterns.

A sticky compare flag records matches. The two-bit alignment field decides which count direction may set the flag: any direction, only down, only up, or both.

The counter is a two-state machine. The states are `ST_UP` and `ST_DOWN`.

- In `ST_UP`, the transition *rise* adds one to the count. In edge-aligned mode, the transition *wrap* returns the count to zero at the limit. In centre-aligned mode, the transition *peak* moves to `ST_DOWN` at the limit and subtracts one.
- In `ST_DOWN`, the transition *fall* subtracts one. The transition *trough* moves back to `ST_UP` at zero and loads one. If the alignment is switched to edge-aligned while in `ST_DOWN`, the transition *realign* returns to `ST_UP` with a count of zero.
- When the enable is low, every state holds (*idle*).

Top module: `tmr_cmp_chan`

## Requirements
- R1: After reset the counter is 0, `dir_down` is 0 (counting up), `oc_prep` is 0 and `cmp_flag` is 0.
- R2: With `ca_mode` = 2'b00 and `en` high, each clock adds one to the counter. When the counter equals `arr`, the next clock sets it to 0. `dir_down` stays 0.
- R3: With `ca_mode` nonzero and `en` high, the counter counts 0 up to `arr` and then back down to 0, repeatedly. `dir_down` is 0 while the value is on its way up, including the value `arr`. It is 1 on the way down, including the value 0. After 0 reached while counting down, the next value is 1, counting up.
- R4: A match is a cycle with `en` high and counter equal to `cmp_val`. For `oc_mode` 0, `oc_prep` keeps its level. For `oc_mode` 1, a match makes `oc_prep` 1 at the next clock. For `oc_mode` 2, a match makes `oc_prep` 0 at the next clock.
- R5: With `oc_mode` 3, every match inverts `oc_prep` at the next clock.
- R6: With `oc_mode` 4, `oc_prep` is 0 from the next clock on. With `oc_mode` 5, it is 1 from the next clock on. The counter value does not matter in either mode.
- R7: With `oc_mode` 6, `oc_prep` at each clock becomes 1 when the counter was below `cmp_val` and 0 otherwise. With `oc_mode` 7, it becomes the inverse of that.
- R8: A match sets `cmp_flag` at the next clock when its direction qualifies. For `ca_mode` 00 or 11, every match qualifies. For 01, only matches with `dir_down` 1 qualify. For 10, only matches with `dir_down` 0 qualify.
- R9: `cmp_flag` stays 1 until a clock where `flag_clr` is high. If a qualifying match occurs in that same cycle, the flag stays 1.
- R10: While `en` is low, the counter and `dir_down` hold, and no match action or flag set occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Counter enable; also gates match detection |
| arr | input | CNT_W | Reload limit (top of count) |
| cmp_val | input | CNT_W | Compare value |
| oc_mode | input | 3 | Output-prepare mode, 0..7 as in R4–R7 |
| ca_mode | input | 2 | Alignment: 00 edge, 01/10/11 centre with flag direction per R8 |
| flag_clr | input | 1 | One-cycle clear strobe for the compare flag |
| oc_prep | output | 1 | Registered output-prepare level |
| cnt | output | CNT_W | Current counter value |
| dir_down | output | 1 | 1 while counting down |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
A qualifying compare match and a flag-clear strobe can land in the same cycle. The bench holds `flag_clr` high across the first three enabled clocks while `cmp_val` is 2. It then judges that the flag reads 0 after the first two clocks and 1 after the third, the cycle in which set and clear collided. The counter's turn at the limit also coincides with a match when `cmp_val` equals `arr`. The bench places a match on the peak and one on the trough and checks that the alignment field credits each to the correct direction.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [2:0] {
        OM_HOLD    = 3'd0,
        OM_SET     = 3'd1,
        OM_CLEAR   = 3'd2,
        OM_TOGGLE  = 3'd3,
        OM_FORCE_0 = 3'd4,
        OM_FORCE_1 = 3'd5,
        OM_PWM_LO  = 3'd6,
        OM_PWM_HI  = 3'd7
    } oc_mode_e;

    typedef enum logic [1:0] {
        CA_EDGE   = 2'b00,
        CA_DN     = 2'b01,
        CA_UP     = 2'b10,
        CA_BOTH   = 2'b11
    } ca_mode_e;

    typedef enum logic {
        ST_UP   = 1'b0,
        ST_DOWN = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/tcc_counter.sv
module tcc_counter
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] arr,
    input  logic [1:0]       ca_mode,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             edge_al;

    assign edge_al = (ca_mode_e'(ca_mode) == CA_EDGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UP;
            cnt_q   <= ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (en) begin
            unique case (state_q)
                ST_UP: begin
                    if (edge_al) begin
                        cnt_d = (cnt_q >= arr) ? ZERO : cnt_q + ONE;
                    end else if (cnt_q >= arr) begin
                        state_d = ST_DOWN;
                        cnt_d   = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                ST_DOWN: begin
                    if (edge_al) begin
                        state_d = ST_UP;
                        cnt_d   = ZERO;
                    end else if (cnt_q == ZERO) begin
                        state_d = ST_UP;
                        cnt_d   = (arr == ZERO) ? ZERO : ONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: begin
                    state_d = ST_UP;
                    cnt_d   = ZERO;
                end
            endcase
        end
    end

    assign cnt      = cnt_q;
    assign dir_down = (state_q == ST_DOWN);

endmodule

// File: rtl/tcc_prep.sv
module tcc_prep
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [2:0]       oc_mode,
    output logic             oc_prep
);
    logic prep_q, prep_d;
    logic hit, below;

    assign hit   = en && (cnt == cmp_val);
    assign below = (cnt < cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prep_q <= 1'b0;
        else        prep_q <= prep_d;
    end

    always_comb begin
        prep_d = prep_q;
        unique case (oc_mode_e'(oc_mode))
            OM_HOLD:    prep_d = prep_q;
            OM_SET:     if (hit) prep_d = 1'b1;
            OM_CLEAR:   if (hit) prep_d = 1'b0;
            OM_TOGGLE:  if (hit) prep_d = ~prep_q;
            OM_FORCE_0: prep_d = 1'b0;
            OM_FORCE_1: prep_d = 1'b1;
            OM_PWM_LO:  prep_d = below;
            OM_PWM_HI:  prep_d = ~below;
            default:    prep_d = prep_q;
        endcase
    end

    assign oc_prep = prep_q;

endmodule

// File: rtl/tcc_flag.sv
module tcc_flag
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             dir_down,
    input  logic [1:0]       ca_mode,
    input  logic             flag_clr,
    output logic             cmp_flag
);
    logic flag_q, flag_d;
    logic dir_ok, set_now;

    always_comb begin
        unique case (ca_mode_e'(ca_mode))
            CA_EDGE: dir_ok = 1'b1;
            CA_DN:   dir_ok = dir_down;
            CA_UP:   dir_ok = ~dir_down;
            CA_BOTH: dir_ok = 1'b1;
            default: dir_ok = 1'b0;
        endcase
    end

    assign set_now = en && (cnt == cmp_val) && dir_ok;

    always_comb flag_d = set_now | (flag_q & ~flag_clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign cmp_flag = flag_q;

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] arr,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [2:0]       oc_mode,
    input  logic [1:0]       ca_mode,
    input  logic             flag_clr,
    output logic             oc_prep,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             cmp_flag
);
    logic [CNT_W-1:0] cnt_w;
    logic             dir_w;

    tcc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .arr      (arr),
        .ca_mode  (ca_mode),
        .cnt      (cnt_w),
        .dir_down (dir_w)
    );

    tcc_prep #(.CNT_W(CNT_W)) u_prep (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cnt      (cnt_w),
        .cmp_val  (cmp_val),
        .oc_mode  (oc_mode),
        .oc_prep  (oc_prep)
    );

    tcc_flag #(.CNT_W(CNT_W)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cnt      (cnt_w),
        .cmp_val  (cmp_val),
        .dir_down (dir_w),
        .ca_mode  (ca_mode),
        .flag_clr (flag_clr),
        .cmp_flag (cmp_flag)
    );

    assign cnt      = cnt_w;
    assign dir_down = dir_w;

endmodule

// File: rtl/tmr_cmp_chan_chk.sv
module tmr_cmp_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [CNT_W-1:0] arr,
    input logic [CNT_W-1:0] cmp_val,
    input logic [2:0]       oc_mode,
    input logic [1:0]       ca_mode,
    input logic             flag_clr,
    input logic             oc_prep,
    input logic [CNT_W-1:0] cnt,
    input logic             dir_down,
    input logic             cmp_flag
);
    assert_edge_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ca_mode == 2'b00 && cnt == arr) |=> (cnt == '0 && !dir_down));

    assert_trough_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ca_mode != 2'b00 && dir_down && cnt == '0) |=> !dir_down);

    assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_mode == 3'd3 && en && cnt == cmp_val) |=> (oc_prep != $past(oc_prep)));

    assert_force_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_mode == 3'd4) |=> !oc_prep);

    assert_force_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_mode == 3'd5) |=> oc_prep);

    assert_edge_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ca_mode == 2'b00 && cnt == cmp_val) |=> cmp_flag);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && flag_clr) |=> !cmp_flag);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(cnt) && $stable(dir_down)));

endmodule

bind tmr_cmp_chan tmr_cmp_chan_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tmr_cmp_chan_tb_top.sv
module tmr_cmp_chan_tb_top;
    localparam int W = 16;

    typedef struct packed {
        logic [2:0] mode;
        logic [1:0] ca;
        logic [7:0] cmpv;
        logic [7:0] n;
        logic [7:0] e_cnt;
        logic       e_dir;
        logic       e_prep;
        logic       e_flag;
    } vec_t;

    // All vectors use arr = 5
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{3'd6, 2'd0, 8'd3, 8'd2,  8'd2, 1'b0, 1'b1, 1'b0},
        '{3'd6, 2'd0, 8'd3, 8'd4,  8'd4, 1'b0, 1'b0, 1'b1},
        '{3'd7, 2'd0, 8'd3, 8'd2,  8'd2, 1'b0, 1'b0, 1'b0},
        '{3'd7, 2'd0, 8'd3, 8'd5,  8'd5, 1'b0, 1'b1, 1'b1},
        '{3'd1, 2'd0, 8'd2, 8'd2,  8'd2, 1'b0, 1'b0, 1'b0},
        '{3'd1, 2'd0, 8'd2, 8'd3,  8'd3, 1'b0, 1'b1, 1'b1},
        '{3'd3, 2'd0, 8'd2, 8'd3,  8'd3, 1'b0, 1'b1, 1'b1},
        '{3'd3, 2'd0, 8'd2, 8'd9,  8'd3, 1'b0, 1'b0, 1'b1},
        '{3'd5, 2'd0, 8'd2, 8'd1,  8'd1, 1'b0, 1'b1, 1'b0},
        '{3'd4, 2'd0, 8'd2, 8'd3,  8'd3, 1'b0, 1'b0, 1'b1},
        '{3'd2, 2'd0, 8'd2, 8'd3,  8'd3, 1'b0, 1'b0, 1'b1},
        '{3'd0, 2'd1, 8'd3, 8'd5,  8'd5, 1'b0, 1'b0, 1'b0},
        '{3'd0, 2'd1, 8'd3, 8'd8,  8'd2, 1'b1, 1'b0, 1'b1},
        '{3'd0, 2'd2, 8'd3, 8'd4,  8'd4, 1'b0, 1'b0, 1'b1},
        '{3'd0, 2'd1, 8'd5, 8'd12, 8'd2, 1'b0, 1'b0, 1'b0},
        '{3'd0, 2'd1, 8'd0, 8'd11, 8'd1, 1'b0, 1'b0, 1'b1},
        '{3'd0, 2'd2, 8'd0, 8'd1,  8'd1, 1'b0, 1'b0, 1'b1},
        '{3'd0, 2'd3, 8'd4, 8'd5,  8'd5, 1'b0, 1'b0, 1'b1},
        '{3'd6, 2'd3, 8'd3, 8'd8,  8'd2, 1'b1, 1'b0, 1'b1},
        '{3'd6, 2'd3, 8'd3, 8'd9,  8'd1, 1'b1, 1'b1, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] arr = 16'd5;
    logic [W-1:0] cmp_val = '0;
    logic [2:0]   oc_mode = '0;
    logic [1:0]   ca_mode = '0;
    logic         flag_clr = 1'b0;
    logic         oc_prep, dir_down, cmp_flag;
    logic [W-1:0] cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tmr_cmp_chan #(.CNT_W(W)) dut_i (.*);

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic string prep_req(input logic [2:0] m);
        if (m <= 3'd2)      return "R4";
        else if (m == 3'd3) return "R5";
        else if (m <= 3'd5) return "R6";
        else                return "R7";
    endfunction

    task automatic restart(input logic [2:0] m, input logic [1:0] ca, input logic [W-1:0] cv);
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; flag_clr = 1'b0;
        oc_mode = m; ca_mode = ca; cmp_val = cv;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; en = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "cnt", int'(cnt), 0);
        chk("R1", "dir_down", int'(dir_down), 0);
        chk("R1", "oc_prep", int'(oc_prep), 0);
        chk("R1", "cmp_flag", int'(cmp_flag), 0);

        // Vector table walk: R2/R3 counting, R4-R7 prepare, R8 flag
        for (int i = 0; i < NV; i++) begin
            restart(VECS[i].mode, VECS[i].ca, W'(VECS[i].cmpv));
            repeat (int'(VECS[i].n)) @(posedge clk);
            @(negedge clk);
            chk((VECS[i].ca == 2'd0) ? "R2" : "R3", $sformatf("v%0d cnt", i),
                int'(cnt), int'(VECS[i].e_cnt));
            chk((VECS[i].ca == 2'd0) ? "R2" : "R3", $sformatf("v%0d dir", i),
                int'(dir_down), int'(VECS[i].e_dir));
            chk(prep_req(VECS[i].mode), $sformatf("v%0d prep", i),
                int'(oc_prep), int'(VECS[i].e_prep));
            chk("R8", $sformatf("v%0d flag", i), int'(cmp_flag), int'(VECS[i].e_flag));
        end

        // R9: clear held across first three clocks; match on the third collides
        restart(3'd0, 2'd0, 16'd2);
        flag_clr = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9", "flag during clear", int'(cmp_flag), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R9", "set beats clear", int'(cmp_flag), 1);
        flag_clr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9", "flag sticky", int'(cmp_flag), 1);

        // R10: enable low holds counter, no toggle, then clear works
        restart(3'd3, 2'd0, 16'd2);
        repeat (2) @(posedge clk);
        @(negedge clk);
        en = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10", "cnt held", int'(cnt), 2);
        chk("R10", "no toggle while idle", int'(oc_prep), 0);
        chk("R10", "no flag while idle", int'(cmp_flag), 0);
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R5", "toggle after resume", int'(oc_prep), 1);
        en = 1'b0; flag_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R9", "flag cleared", int'(cmp_flag), 0);

        // R6: force modes change on next edge while idle
        oc_mode = 3'd4;
        @(posedge clk);
        @(negedge clk);
        chk("R6", "force low", int'(oc_prep), 0);
        oc_mode = 3'd5;
        @(posedge clk);
        @(negedge clk);
        chk("R6", "force high", int'(oc_prep), 1);

        finish_run();
    end

endmodule